// File: doc/BRIEF.md
# Cycle-by-Cycle Current-Limit Gate Controller

This block is the synchronous protection and gating logic behind a two-channel low-side gate driver. Two PWM commands from a host pass through to two gate-enable outputs unless an over-current is seen on a single sense sample shared by both channels. When that happens, both gates are forced low at once and a limit flag is raised. The flag stays set, so the host can poll it, until a fresh PWM rising edge shows that the fault has gone.

The sense sample and the limit threshold arrive as unsigned ADC codes with one code per millivolt. The threshold either comes from the host, and is clamped into its legal window, or falls back to a default when the host flags it as not driven. The limit flag also acts as a start-up handshake. It stays high until both supply-good inputs are asserted, and it drops only when the block is ready to pass pulses.

The controller has three states. `ST_WAIT_SUPPLY` is entered from reset and whenever a supply flag drops. `ST_RUN` passes pulses. `ST_LATCHED` holds after a fault. The transitions are:
- wait→run: supplies good and no fault.
- wait→latched: supplies good with a fault present.
- run→latched: fault.
- latched→run: a synchronized PWM rising edge on either channel with no fault in the same cycle.
- any→wait: a supply flag low.

Top module: `ocp_gate_ctrl`

## Requirements
- R1: While reset is asserted, and on release, both gates are low and the limit flag is high.
- R2: The limit flag stays high while either supply-good input is low. In the first clock after both are high with no fault, the flag goes low.
- R3: A fault is present when sense + 25 > effective threshold, which means the sense code exceeds the threshold minus 25 codes. Sense equal to the threshold minus 25 is not a fault.
- R4: In the clock after a fault is present, both gates are low and the limit flag is high.
- R5: A supplied threshold from 1 to 249 is used as 250, and one above 1000 is used as 1000. A supplied threshold of 0 is used as 0, so a zero sense code keeps the flag latched through PWM pulses.
- R6: When the threshold-open input is high, the effective threshold is 500, whatever the threshold code.
- R7: Once latched, the flag stays high until a synchronized rising edge on either PWM input arrives in a cycle with no fault. The flag clears in the clock after that edge.
- R8: After a fault, a channel's gate stays low even while its PWM stays high with the fault gone. It resumes only after that channel's own next rising edge.
- R9: If a fault and a PWM rising edge occur in the same cycle, the fault wins: the flag stays high and both gates stay low.
- R10: With supplies good and no fault, each gate follows its own PWM input three clocks later: two synchronizer flops and the output register.
- R11: When a supply-good input drops, both gates go low and the flag goes high in the next clock. When the supply returns with no fault, both channels are re-armed and follow their PWM levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_a | input | 1 | PWM command, channel A (asynchronous) |
| pwm_b | input | 1 | PWM command, channel B (asynchronous) |
| vdd_ok | input | 1 | Main supply good |
| rail_ok | input | 1 | Logic rail good |
| thr_open | input | 1 | High when no threshold is supplied |
| thr_code | input | CODE_W | Supplied current-limit threshold code |
| sense_code | input | CODE_W | Shared current-sense code |
| gate_a | output | 1 | Gate enable, channel A |
| gate_b | output | 1 | Gate enable, channel B |
| limit_flag | output | 1 | Latched current-limit / not-ready flag |

## Verification
The assertions take the sense code, the threshold code, the open indication and the supply flags as already synchronous to the clock and stable across each edge. Only the two PWM inputs are treated as asynchronous. The stimulus honours this by changing every input one time unit after a rising edge and holding it until the next one. The random phase holds each PWM level for several clocks, so both synchronized edges and mid-pulse faults occur. It keeps the sense code mostly below the clamp floor and only occasionally sweeps the full code range, so latched and running periods both get long stretches.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_SUPPLY = 2'd0,
        ST_RUN         = 2'd1,
        ST_LATCHED     = 2'd2
    } ctrl_state_t;

endpackage

// File: rtl/ocp_pwm_sync.sv
module ocp_pwm_sync #(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pwm_in,
    output logic [N_CH-1:0] lvl,
    output logic [N_CH-1:0] rise
);

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
            logic meta_q, sync_q, prev_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    meta_q <= pwm_in[ch];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end

            assign lvl[ch]  = sync_q;
            assign rise[ch] = sync_q & ~prev_q;

            // R10: a synchronized rising edge lasts exactly one cycle
            p_rise_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
                rise[ch] |=> !rise[ch]);
        end
    endgenerate

endmodule

// File: rtl/ocp_thr_cmp.sv
module ocp_thr_cmp #(
    parameter int CODE_W      = 10,
    parameter int OFFSET_CODE = 25,
    parameter int DFLT_CODE   = 500,
    parameter int MIN_CODE    = 250,
    parameter int MAX_CODE    = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_open,
    input  logic [CODE_W-1:0] thr_code,
    input  logic [CODE_W-1:0] sense_code,
    output logic [CODE_W-1:0] thr_eff,
    output logic              over
);

    localparam int SUM_W = CODE_W + 1;
    localparam logic [CODE_W-1:0] DFLT_V = CODE_W'(DFLT_CODE);
    localparam logic [CODE_W-1:0] MIN_V  = CODE_W'(MIN_CODE);
    localparam logic [CODE_W-1:0] MAX_V  = CODE_W'(MAX_CODE);
    localparam logic [SUM_W-1:0]  OFF_V  = SUM_W'(OFFSET_CODE);

    logic [SUM_W-1:0] sense_plus;

    always_comb begin
        if (thr_open)
            thr_eff = DFLT_V;
        else if (thr_code == '0)
            thr_eff = '0;
        else if (thr_code < MIN_V)
            thr_eff = MIN_V;
        else if (thr_code > MAX_V)
            thr_eff = MAX_V;
        else
            thr_eff = thr_code;
    end

    assign sense_plus = {1'b0, sense_code} + OFF_V;
    assign over       = sense_plus > {1'b0, thr_eff};

    // R5: the threshold fed to the compare is zero or inside the window
    p_thr_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_eff == '0) || (thr_eff >= MIN_V && thr_eff <= MAX_V));

    // R6: open threshold selects the default
    p_thr_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
        thr_open |-> thr_eff == DFLT_V);

endmodule

// File: rtl/ocp_ctrl_fsm.sv
module ocp_ctrl_fsm
    import ocp_pkg::*;
#(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sup_ok,
    input  logic            over,
    input  logic [N_CH-1:0] lvl,
    input  logic [N_CH-1:0] rise,
    output logic [N_CH-1:0] gate,
    output logic            flag
);

    ctrl_state_t     state, state_n;
    logic [N_CH-1:0] arm, arm_n;

    always_comb begin
        state_n = state;
        arm_n   = arm;
        if (!sup_ok) begin
            state_n = ST_WAIT_SUPPLY;
            arm_n   = '1;
        end else begin
            unique case (state)
                ST_WAIT_SUPPLY: begin
                    if (over) begin
                        state_n = ST_LATCHED;
                        arm_n   = '0;
                    end else begin
                        state_n = ST_RUN;
                        arm_n   = '1;
                    end
                end
                ST_RUN: begin
                    if (over) begin
                        state_n = ST_LATCHED;
                        arm_n   = '0;
                    end else begin
                        arm_n = arm | rise;
                    end
                end
                ST_LATCHED: begin
                    if (!over && (|rise)) begin
                        state_n = ST_RUN;
                        arm_n   = rise;
                    end else begin
                        arm_n = '0;
                    end
                end
                default: begin
                    state_n = ST_WAIT_SUPPLY;
                    arm_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT_SUPPLY;
            arm   <= '0;
        end else begin
            state <= state_n;
            arm   <= arm_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate <= '0;
            flag <= 1'b1;
        end else begin
            gate <= (state_n == ST_RUN) ? (arm_n & lvl) : '0;
            flag <= (state_n != ST_RUN);
        end
    end

    // R4: a fault turns every gate off and raises the flag next cycle
    p_fault_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        over |=> (flag && gate == '0));

    // R9: fault beats a simultaneous rising edge
    p_fault_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCHED && over && (|rise)) |=> flag);

    // R7: latched flag holds while no edge arrives
    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCHED && !(|rise)) |=> flag);

    // R8: a disarmed channel cannot drive its gate before its own edge
    p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !arm[0] && !rise[0] && sup_ok) |=> !gate[0]);

endmodule

// File: rtl/ocp_gate_ctrl.sv
module ocp_gate_ctrl #(
    parameter int CODE_W      = 10,
    parameter int OFFSET_CODE = 25,
    parameter int DFLT_CODE   = 500,
    parameter int MIN_CODE    = 250,
    parameter int MAX_CODE    = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_a,
    input  logic              pwm_b,
    input  logic              vdd_ok,
    input  logic              rail_ok,
    input  logic              thr_open,
    input  logic [CODE_W-1:0] thr_code,
    input  logic [CODE_W-1:0] sense_code,
    output logic              gate_a,
    output logic              gate_b,
    output logic              limit_flag
);

    localparam int N_CH = 2;

    logic [N_CH-1:0]   lvl, rise, gate;
    logic [CODE_W-1:0] thr_eff;
    logic              over;
    logic              sup_ok;

    assign sup_ok = vdd_ok & rail_ok;

    ocp_pwm_sync #(.N_CH(N_CH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwm_in ({pwm_b, pwm_a}),
        .lvl    (lvl),
        .rise   (rise)
    );

    ocp_thr_cmp #(
        .CODE_W      (CODE_W),
        .OFFSET_CODE (OFFSET_CODE),
        .DFLT_CODE   (DFLT_CODE),
        .MIN_CODE    (MIN_CODE),
        .MAX_CODE    (MAX_CODE)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .thr_open   (thr_open),
        .thr_code   (thr_code),
        .sense_code (sense_code),
        .thr_eff    (thr_eff),
        .over       (over)
    );

    ocp_ctrl_fsm #(.N_CH(N_CH)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sup_ok (sup_ok),
        .over   (over),
        .lvl    (lvl),
        .rise   (rise),
        .gate   (gate),
        .flag   (limit_flag)
    );

    assign gate_a = gate[0];
    assign gate_b = gate[1];

    // R11: supply loss forces gates off and raises the flag
    p_supply_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(vdd_ok && rail_ok) |=> (limit_flag && !gate_a && !gate_b));

    // R2: the flag is never low while a supply is bad
    p_handshake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(vdd_ok && rail_ok) |=> limit_flag);

endmodule

// File: tb/sim_ocp_gate_ctrl.sv
module sim_ocp_gate_ctrl;

    localparam int CW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_a = 1'b0, pwm_b = 1'b0, vdd_ok = 1'b0, rail_ok = 1'b0, thr_open = 1'b1;
    logic [CW-1:0] thr_code = '0, sense_code = '0;
    logic gate_a, gate_b, limit_flag;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic ma1, ma2, ma3, mb1, mb2, mb3;
    int   mst;          // 0 wait, 1 run, 2 latched
    logic marm_a, marm_b, mg_a, mg_b, mflag;

    always #4 clk = ~clk;   // 125 MHz

    ocp_gate_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .vdd_ok(vdd_ok), .rail_ok(rail_ok), .thr_open(thr_open),
        .thr_code(thr_code), .sense_code(sense_code),
        .gate_a(gate_a), .gate_b(gate_b), .limit_flag(limit_flag)
    );

    function automatic int exp_thr(input logic op, input int t);
        if (op) return 500;
        if (t == 0) return 0;
        if (t < 250) return 250;
        if (t > 1000) return 1000;
        return t;
    endfunction

    function automatic bit exp_fault(input int s, input logic op, input int t);
        return (s + 25) > exp_thr(op, t);
    endfunction

    task automatic model_step();
        bit sok, flt, ra, rb;
        int nst;
        logic na, nb;
        if (!rst_n) begin
            {ma1, ma2, ma3, mb1, mb2, mb3} = '0;
            mst = 0; marm_a = 0; marm_b = 0; mg_a = 0; mg_b = 0; mflag = 1;
            return;
        end
        sok = vdd_ok && rail_ok;
        flt = exp_fault(int'(sense_code), thr_open, int'(thr_code));
        ra = ma2 && !ma3;
        rb = mb2 && !mb3;
        nst = mst; na = marm_a; nb = marm_b;
        if (!sok) begin nst = 0; na = 1; nb = 1; end
        else if (mst == 0) begin
            if (flt) begin nst = 2; na = 0; nb = 0; end
            else begin nst = 1; na = 1; nb = 1; end
        end else if (mst == 1) begin
            if (flt) begin nst = 2; na = 0; nb = 0; end
            else begin na = marm_a | ra; nb = marm_b | rb; end
        end else begin
            if (!flt && (ra || rb)) begin nst = 1; na = ra; nb = rb; end
            else begin na = 0; nb = 0; end
        end
        mst = nst; marm_a = na; marm_b = nb;
        mg_a = (nst == 1) && na && ma2;
        mg_b = (nst == 1) && nb && mb2;
        mflag = (nst != 1);
        ma3 = ma2; ma2 = ma1; ma1 = pwm_a;
        mb3 = mb2; mb2 = mb1; mb1 = pwm_b;
    endtask

    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] act;
        act = {gate_a, gate_b, limit_flag};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {gate_a,gate_b,flag} actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic clear_via_b();
        pwm_b = 1'b0; ticks(4);
        pwm_b = 1'b1; ticks(3);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        ticks(3);
        chk("R1 during reset", 3'b001);
        rst_n = 1'b1; tick();
        chk("R1 after release", 3'b001);

        vdd_ok = 1'b1; ticks(3);
        chk("R2 rail still low", 3'b001);
        rail_ok = 1'b1; tick();
        chk("R2 ready handshake", 3'b000);

        pwm_a = 1'b1; ticks(2);
        chk("R10 not yet through sync", 3'b000);
        tick();
        chk("R10 gate follows pwm", 3'b100);

        sense_code = 10'd475; tick();
        chk("R3 R6 boundary no fault at default", 3'b100);
        sense_code = 10'd476; tick();
        chk("R4 fault shuts gates", 3'b001);

        sense_code = 10'd0; ticks(4);
        chk("R7 flag holds without edge", 3'b001);

        pwm_b = 1'b1; ticks(3);
        chk("R8 b edge clears, a stays off", 3'b010);

        pwm_a = 1'b0; ticks(4);
        pwm_a = 1'b1; ticks(3);
        chk("R8 a re-armed by own edge", 3'b110);

        pwm_a = 1'b0; ticks(4);
        pwm_a = 1'b1; ticks(2);
        sense_code = 10'd600; tick();
        chk("R9 fault with edge", 3'b001);
        sense_code = 10'd0; ticks(3);
        chk("R9 fault won, still latched", 3'b001);

        thr_open = 1'b0; thr_code = 10'd100; clear_via_b();
        chk("R7 cleared by b edge", 3'b010);
        sense_code = 10'd225; tick();
        chk("R5 low clamp no fault", 3'b010);
        sense_code = 10'd226; tick();
        chk("R5 low clamp fault", 3'b001);

        sense_code = 10'd0; thr_code = 10'd1023; clear_via_b();
        sense_code = 10'd975; tick();
        chk("R5 high clamp no fault", 3'b010);
        sense_code = 10'd976; tick();
        chk("R5 high clamp fault", 3'b001);

        sense_code = 10'd0; thr_code = 10'd0; clear_via_b();
        chk("R5 zero threshold stays latched", 3'b001);

        thr_open = 1'b1; clear_via_b();
        chk("R6 open threshold runs", 3'b010);
        rail_ok = 1'b0; tick();
        chk("R11 supply drop", 3'b001);
        ticks(3);
        chk("R2 flag high while supply bad", 3'b001);
        rail_ok = 1'b1; tick();
        chk("R11 supply back re-arms", 3'b110);

        for (int cyc = 0; cyc < 3000; cyc++) begin
            if ($urandom % 8 == 0) pwm_a = ~pwm_a;
            if ($urandom % 8 == 0) pwm_b = ~pwm_b;
            sense_code = ($urandom % 12 == 0) ? CW'($urandom % 1024) : CW'($urandom % 200);
            if (cyc % 64 == 0) begin
                thr_open = 1'($urandom % 2);
                thr_code = CW'($urandom % 1024);
            end
            rail_ok = ($urandom % 150 != 0);
            vdd_ok  = ($urandom % 300 != 0);
            tick();
            chk("R10 random vs model", {mg_a, mg_b, mflag});
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule